// File: doc/BRIEF.md
# Perspective Divide and Screen Projection

This block turns a point already moved into view space into a 2D screen position. It divides the projection-plane distance by the point's depth to get a scale factor. It then multiplies the two view-space lateral components by that factor, adds a 16.16 fixed-point screen offset to each, and keeps the integer part. The integer part is clamped to an 11-bit signed screen window.

A single-cycle `start` pulse launches one operation. While the unit works, `busy` is high and further `start` pulses are dropped. A one-cycle `done` pulse marks the cycle in which the screen coordinates and the three status bits become valid. These are the divide-overflow bit and one clip bit per axis, and they stay unchanged until the next `done`.

The divider is a restoring unit that produces one quotient bit per clock. When the overflow rule fires, the divider is skipped and the quotient takes its saturated value. This shortens that path to two cycles.

Top module: `persp_proj_unit`

## Requirements
- R1: `div_ovf` is 1 when `h_dist >= 2*depth`, compared over the full unsigned range and boundary included. This covers `depth = 0` (for example h=200 or 201 with depth=100, or h=5 with depth=0).
- R2: When `h_dist < 2*depth`, `div_ovf` is 0 and the quotient is q = floor((floor(h_dist*2^17/depth) + 1) / 2). For example h=199 with depth=100 gives q=130417, and h=2 with depth=3 gives q=43691.
- R3: On divide overflow the quotient is forced to 0x1FFFF.
- R4: Before clamping, `scr_x` = floor((ofs_x + ir_x*q) / 2^16) and `scr_y` = floor((ofs_y + ir_y*q) / 2^16). The offsets are signed 16.16, the lateral inputs are signed integers, and the shift is arithmetic.
- R5: A coordinate above 1023 is output as 1023, and one below -1024 is output as -1024. In either case the axis clip bit (`clip_x` or `clip_y`) is 1.
- R6: Coordinates of exactly 1023 or -1024 pass unchanged with the clip bit at 0.
- R7: With `h_dist = 0` and nonzero depth, the quotient is 0 and no overflow is flagged, so each coordinate equals its offset's integer part (clamped per R5).
- R8: `done` is high for exactly one cycle per accepted operation. The coordinates and status bits change only in that cycle and hold their value until the next `done`.
- R9: A `start` pulse while `busy` is high is ignored. The running operation completes with its own inputs and yields a single `done`.
- R10: After reset, `scr_x`, `scr_y`, `div_ovf`, `clip_x`, `clip_y`, `done` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; inputs sampled in this cycle |
| h_dist | input | 16 | Projection-plane distance, unsigned |
| depth | input | 16 | Point depth, unsigned divisor |
| ir_x | input | 16 | Lateral X component, signed |
| ir_y | input | 16 | Lateral Y component, signed |
| ofs_x | input | 32 | Screen X offset, signed 16.16 |
| ofs_y | input | 32 | Screen Y offset, signed 16.16 |
| busy | output | 1 | Operation in flight; `start` ignored |
| done | output | 1 | One-cycle result-valid pulse |
| scr_x | output | 16 | Screen X, signed, clamped |
| scr_y | output | 16 | Screen Y, signed, clamped |
| div_ovf | output | 1 | Divide overflow status |
| clip_x | output | 1 | X coordinate was clamped |
| clip_y | output | 1 | Y coordinate was clamped |

## Verification
The assertions assume that `start` is a pulse from a master that respects `busy`, and that the inputs are valid in the cycle `start` is sampled. They do not need the inputs to stay stable after that cycle, because the unit captures them. The bench raises `start` for exactly one cycle at a falling edge and changes the inputs only at falling edges. It deliberately pulses `start` during a running division to exercise the drop rule. All stimulus values stay within the declared port widths. This keeps the divider remainder invariant and the clamp checks meaningful without any further input constraint.

// File: rtl/persp_pkg.sv
package persp_pkg;

    localparam int DEPTH_W = 16;
    localparam int IR_W    = 16;
    localparam int OFS_W   = 32;
    localparam int FRAC_W  = 16;
    localparam int QUOT_W  = 17;
    localparam int COORD_W = 16;
    localparam int AXES    = 2;

    localparam int SCR_HI  = 1023;
    localparam int SCR_LO  = -1024;

    typedef enum logic {
        DV_IDLE,
        DV_RUN
    } div_state_e;

    typedef struct packed {
        logic ovf;
        logic clip_x;
        logic clip_y;
    } proj_flags_t;

    function automatic logic ovf_rule(input logic [DEPTH_W-1:0] num,
                                      input logic [DEPTH_W-1:0] den);
        return {1'b0, num} >= {den, 1'b0};
    endfunction

endpackage

// File: rtl/persp_divider.sv
module persp_divider
    import persp_pkg::*;
#(
    parameter int ZW = DEPTH_W,
    parameter int QW = QUOT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [ZW-1:0] num,
    input  logic [ZW-1:0] den,
    output logic          busy,
    output logic          valid,
    output logic          ovf,
    output logic [QW-1:0] quot
);
    localparam int NB   = QW + 1;
    localparam int RW   = ZW + 2;
    localparam int CNTW = $clog2(NB);
    localparam logic [QW-1:0] QMAX = '1;

    div_state_e    state;
    logic [RW-1:0] rem, shifted, diff, dsr_ext;
    logic [ZW-1:0] dsr;
    logic [NB-1:0] qacc, qnext;
    logic [NB:0]   rounded;
    logic [CNTW-1:0] cnt;
    logic          take, ovf_now;

    always_comb begin
        ovf_now = ({1'b0, num} >= {den, 1'b0});
        dsr_ext = RW'(dsr);
        shifted = (cnt == '0) ? rem : {rem[RW-2:0], 1'b0};
        take    = (shifted >= dsr_ext);
        diff    = shifted - dsr_ext;
        qnext   = {qacc[NB-2:0], take};
        rounded = ({1'b0, qnext} + (NB+1)'(1)) >> 1;
    end

    assign busy = (state == DV_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DV_IDLE;
            rem   <= '0;
            dsr   <= '0;
            qacc  <= '0;
            cnt   <= '0;
            quot  <= '0;
            ovf   <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                DV_IDLE: begin
                    if (start) begin
                        ovf <= ovf_now;
                        if (ovf_now) begin
                            quot  <= QMAX;
                            valid <= 1'b1;
                        end else begin
                            rem   <= RW'(num);
                            dsr   <= den;
                            qacc  <= '0;
                            cnt   <= '0;
                            state <= DV_RUN;
                        end
                    end
                end
                DV_RUN: begin
                    rem  <= take ? diff : shifted;
                    qacc <= qnext;
                    cnt  <= cnt + CNTW'(1);
                    if (cnt == CNTW'(NB-1)) begin
                        valid <= 1'b1;
                        state <= DV_IDLE;
                        quot  <= (rounded > (NB+1)'(QMAX)) ? QMAX : rounded[QW-1:0];
                    end
                end
                default: state <= DV_IDLE;
            endcase
        end
    end

    AST_OVF_QUOT: assert property (@(posedge clk) disable iff (rst)
        (valid && ovf) |-> (quot == QMAX)); // R3
    AST_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
        (valid && !ovf) |-> (rem < RW'(dsr))); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R8

endmodule

// File: rtl/persp_axis.sv
module persp_axis
    import persp_pkg::*;
#(
    parameter int IW = IR_W,
    parameter int OW = OFS_W,
    parameter int QW = QUOT_W,
    parameter int FW = FRAC_W,
    parameter int CW = COORD_W
) (
    input  logic signed [IW-1:0] ir,
    input  logic signed [OW-1:0] ofs,
    input  logic        [QW-1:0] quot,
    output logic signed [CW-1:0] coord,
    output logic                 clip
);
    localparam int PW = IW + QW + 1;
    localparam int SW = ((OW > PW) ? OW : PW) + 1;

    logic signed [SW-1:0] prod, sum, scaled, lim_hi, lim_lo;

    always_comb begin
        lim_hi = SW'(SCR_HI);
        lim_lo = SW'(SCR_LO);
        prod   = SW'(ir) * SW'($signed({1'b0, quot}));
        sum    = prod + SW'(ofs);
        scaled = sum >>> FW;
        if (scaled > lim_hi) begin
            coord = CW'(lim_hi);
            clip  = 1'b1;
        end else if (scaled < lim_lo) begin
            coord = CW'(lim_lo);
            clip  = 1'b1;
        end else begin
            coord = CW'(scaled);
            clip  = 1'b0;
        end
    end

endmodule

// File: rtl/persp_proj_unit.sv
module persp_proj_unit
    import persp_pkg::*;
#(
    parameter int ZW = DEPTH_W,
    parameter int IW = IR_W,
    parameter int OW = OFS_W,
    parameter int QW = QUOT_W,
    parameter int FW = FRAC_W,
    parameter int CW = COORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic        [ZW-1:0] h_dist,
    input  logic        [ZW-1:0] depth,
    input  logic signed [IW-1:0] ir_x,
    input  logic signed [IW-1:0] ir_y,
    input  logic signed [OW-1:0] ofs_x,
    input  logic signed [OW-1:0] ofs_y,
    output logic                 busy,
    output logic                 done,
    output logic signed [CW-1:0] scr_x,
    output logic signed [CW-1:0] scr_y,
    output logic                 div_ovf,
    output logic                 clip_x,
    output logic                 clip_y
);
    logic          div_busy, div_valid, div_ovf_w, accept;
    logic [QW-1:0] quot;

    logic signed [IW-1:0] ir_q    [AXES];
    logic signed [OW-1:0] ofs_q   [AXES];
    logic signed [CW-1:0] coord_w [AXES];
    logic signed [CW-1:0] coord_q [AXES];
    logic                 clip_w  [AXES];
    proj_flags_t          flags_q;

    assign busy   = div_busy | div_valid;
    assign accept = start & ~busy;

    persp_divider #(.ZW(ZW), .QW(QW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .num   (h_dist),
        .den   (depth),
        .busy  (div_busy),
        .valid (div_valid),
        .ovf   (div_ovf_w),
        .quot  (quot)
    );

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        persp_axis #(.IW(IW), .OW(OW), .QW(QW), .FW(FW), .CW(CW)) u_axis (
            .ir    (ir_q[g]),
            .ofs   (ofs_q[g]),
            .quot  (quot),
            .coord (coord_w[g]),
            .clip  (clip_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < AXES; i++) begin
                ir_q[i]    <= '0;
                ofs_q[i]   <= '0;
                coord_q[i] <= '0;
            end
            flags_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                ir_q[0]  <= ir_x;
                ir_q[1]  <= ir_y;
                ofs_q[0] <= ofs_x;
                ofs_q[1] <= ofs_y;
            end
            if (div_valid) begin
                for (int i = 0; i < AXES; i++) coord_q[i] <= coord_w[i];
                flags_q <= '{ovf: div_ovf_w, clip_x: clip_w[0], clip_y: clip_w[1]};
                done    <= 1'b1;
            end
        end
    end

    assign scr_x   = coord_q[0];
    assign scr_y   = coord_q[1];
    assign div_ovf = flags_q.ovf;
    assign clip_x  = flags_q.clip_x;
    assign clip_y  = flags_q.clip_y;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(scr_x) && $stable(scr_y) && $stable(div_ovf))); // R8
    AST_SCR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (scr_x >= CW'(SCR_LO)) && (scr_x <= CW'(SCR_HI)) &&
        (scr_y >= CW'(SCR_LO)) && (scr_y <= CW'(SCR_HI))); // R5
    AST_CLIP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        clip_x |-> ((scr_x == CW'(SCR_HI)) || (scr_x == CW'(SCR_LO)))); // R5
    AST_NO_DONE_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> !done); // R9

endmodule

// File: tb/test_persp_proj_unit.sv
module test_persp_proj_unit;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic        [15:0] h_dist, depth;
    logic signed [15:0] ir_x, ir_y;
    logic signed [31:0] ofs_x, ofs_y;
    logic               busy, done, div_ovf, clip_x, clip_y;
    logic signed [15:0] scr_x, scr_y;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    persp_proj_unit i_persp_proj_unit (
        .clk(clk), .rst(rst), .start(start),
        .h_dist(h_dist), .depth(depth),
        .ir_x(ir_x), .ir_y(ir_y), .ofs_x(ofs_x), .ofs_y(ofs_y),
        .busy(busy), .done(done), .scr_x(scr_x), .scr_y(scr_y),
        .div_ovf(div_ovf), .clip_x(clip_x), .clip_y(clip_y)
    );

    typedef struct packed {
        logic        [15:0] h;
        logic        [15:0] sz;
        logic signed [15:0] ix;
        logic signed [15:0] iy;
        logic signed [31:0] ox;
        logic signed [31:0] oy;
        logic signed [15:0] ex;
        logic signed [15:0] ey;
        logic               eo;
        logic               efx;
        logic               efy;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   16'd1000, 16'sd100,   -16'sd50,   32'h03FF0000, 32'hFC000000,  16'sd1023, -16'sd1024, 1'b0, 1'b0, 1'b0}, // R6 R7
        '{16'd200, 16'd100,  16'sd256,   -16'sd256,  32'h0,        32'h0,         16'sd511,  -16'sd512,  1'b1, 1'b0, 1'b0}, // R1 R3
        '{16'd201, 16'd100,  16'sd1,     16'sd0,     32'h0,        32'h0,         16'sd1,    16'sd0,     1'b1, 1'b0, 1'b0}, // R1 R3
        '{16'd199, 16'd100,  16'sd256,   -16'sd256,  32'h0,        32'h0,         16'sd509,  -16'sd510,  1'b0, 1'b0, 1'b0}, // R2 R4
        '{16'd100, 16'd100,  16'sd1000,  16'sd2000,  32'h0,        32'h0,         16'sd1000, 16'sd1023,  1'b0, 1'b0, 1'b1}, // R4 R5
        '{16'd100, 16'd100,  -16'sd2000, -16'sd1024, 32'h0,        32'h0,         -16'sd1024,-16'sd1024, 1'b0, 1'b1, 1'b0}, // R5 R6
        '{16'd0,   16'd5,    16'sd0,     16'sd0,     32'h04000000, 32'h00018000,  16'sd1023, 16'sd1,     1'b0, 1'b1, 1'b0}, // R5 R7
        '{16'd50,  16'd200,  16'sd4096,  -16'sd4096, 32'h0,        32'h0,         16'sd1023, -16'sd1024, 1'b0, 1'b1, 1'b0}, // R2 R5
        '{16'd5,   16'd0,    16'sd0,     16'sd0,     32'hFFFD0000, 32'h7FFF0000,  -16'sd3,   16'sd1023,  1'b1, 1'b0, 1'b1}, // R1 R5
        '{16'd1,   16'd3,    16'sd3,     -16'sd3,    32'h00000001, 32'h0,         16'sd1,    -16'sd1,    1'b0, 1'b0, 1'b0}, // R2 R4
        '{16'd2,   16'd3,    16'sd3,     -16'sd3,    32'h0,        32'h0,         16'sd2,    -16'sd3,    1'b0, 1'b0, 1'b0}  // R2 rounding
    };

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        h_dist = v.h; depth = v.sz; ir_x = v.ix; ir_y = v.iy;
        ofs_x = v.ox; ofs_y = v.oy; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({tag, " done timeout"}, 0, 1);
    endtask

    task automatic check_vec(input string tag, input vec_t v);
        chk({tag, " scr_x R4"}, int'(scr_x), int'(v.ex));
        chk({tag, " scr_y R4"}, int'(scr_y), int'(v.ey));
        chk({tag, " div_ovf R1"}, int'(div_ovf), int'(v.eo));
        chk({tag, " clip_x R5"}, int'(clip_x), int'(v.efx));
        chk({tag, " clip_y R5"}, int'(clip_y), int'(v.efy));
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; h_dist = '0; depth = '0;
        ir_x = '0; ir_y = '0; ofs_x = '0; ofs_y = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10 scr_x", int'(scr_x), 0);
        chk("R10 scr_y", int'(scr_y), 0);
        chk("R10 flags", int'({div_ovf, clip_x, clip_y}), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 busy", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            wait_done($sformatf("vec%0d", i));
            check_vec($sformatf("vec%0d", i), VECS[i]);
            @(negedge clk);
            chk($sformatf("vec%0d R8 done low", i), int'(done), 0);
            chk($sformatf("vec%0d R8 hold x", i), int'(scr_x), int'(VECS[i].ex));
        end

        // R8: outputs hold over idle cycles
        repeat (5) @(negedge clk);
        chk("R8 hold y", int'(scr_y), int'(VECS[NV-1].ey));

        // R9: second start during a running division is dropped
        drive(VECS[3]);
        chk("R9 busy", int'(busy), 1);
        @(negedge clk);
        h_dist = VECS[1].h; depth = VECS[1].sz; ir_x = 16'sd7; ir_y = 16'sd7;
        ofs_x = 32'h01000000; ofs_y = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        check_vec("R9 first op", VECS[3]);
        begin
            int extra = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R9 single done", extra, 0);
        end
        chk("R9 result kept", int'(scr_x), int'(VECS[3].ex));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule